// File: doc/BRIEF.md
# Pattern Receiver Lock and Error Tally

This block is the receiving half of a bit error rate tester. It takes a serial payload stream, one bit per cycle where a valid strobe is high. It holds a local 32-bit reference generator that runs on the same rules as the sending generator: PRBS, repetitive or QRSS feedback, with a programmable length n and tap y. While hunting, received bits are loaded straight into the reference register. Once 32 consecutive received bits agree with the prediction, the block declares lock and the register runs on its own feedback from then on.

While locked, each received bit is compared with the prediction. A 64-entry mismatch history keeps a running error tally. When that tally reaches six, lock is dropped and the hunt starts again. A live bit counter and a live error counter run between performance-monitor update pulses. Each pulse copies both counters into holding outputs and restarts them. A flag reports whether the live error counter is non-zero.

Top module: `bert_rx_monitor`

## Requirements
- R1: After reset, `out_of_sync` is 1, `err_present` is 0 and both holding outputs are 0.
- R2: A cycle with `rx_valid` low has no effect. It is not counted, it does not move the reference register, and it does not change the window or the lock search.
- R3: With `cfg_repeat` and `cfg_qrss` both 0 (PRBS mode), the prediction is bit n XOR bit y of the reference register, where n = `cfg_len_m1`+1 and y = `cfg_tap_m1`+1, and bit 1 is the newest bit. The prediction is forced to 1 when bits 1 to 31 are all zero. Lock is declared on the 32nd consecutive matching bit and no earlier.
- R4: With `cfg_repeat` = 1, the prediction is bit n of the reference register, so a pattern of period n is tracked and locked.
- R5: With `cfg_qrss` = 1, which takes priority over `cfg_repeat`, the feedback is bit 17 XOR bit 20, forced to 1 when bits 1 to 31 are zero. The predicted bit is forced to 1 when bits 1 to 14 are all zero.
- R6: While locked, `out_of_sync` rises at the edge that takes in the 6th mismatch among the last 64 valid bits. Five mismatches within any 64-bit span keep lock, and a mismatch older than 64 valid bits no longer counts.
- R7: Mismatches are counted only while locked, including the one that drops lock. `err_present` is 1 exactly when the live error counter is non-zero.
- R8: On `pm_update`, the holding outputs take the live counts accumulated before that cycle, and the live counters restart. A bit arriving in the same cycle counts toward the new interval.
- R9: Both live counters saturate at all ones instead of wrapping.
- R10: After lock is lost, the reference register keeps its contents. A clean stream then regains lock on exactly its 32nd bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_len_m1 | input | 5 | Pattern length n minus one |
| cfg_tap_m1 | input | 5 | PRBS tap y minus one |
| cfg_repeat | input | 1 | 1 selects repetitive-pattern feedback |
| cfg_qrss | input | 1 | 1 selects QRSS feedback and output forcing |
| rx_valid | input | 1 | Qualifies `rx_bit` as a payload bit |
| rx_bit | input | 1 | Received payload bit |
| pm_update | input | 1 | Performance-monitor update pulse |
| err_present | output | 1 | Live error counter is non-zero |
| out_of_sync | output | 1 | Reference generator is not locked |
| bit_count_hold | output | CNT_W | Bit count captured at the last update |
| err_count_hold | output | CNT_W | Error count captured at the last update |

## Verification
Every result is one register stage away from its stimulus. `out_of_sync`, `err_present` and the live counters change at the clock edge that takes in the valid bit. The holding outputs change at the edge that takes in `pm_update`. The bench therefore drives inputs on the falling edge and checks 1 ns after the following rising edge, once per bit. The lock-count and window-boundary checks are made bit by bit, so an early or late lock, or an early or late loss of lock, shows up as a mismatch on that exact bit.

// File: rtl/bert_rx_pkg.sv
package bert_rx_pkg;
  localparam int REF_W = 32;
  localparam int SEL_W = $clog2(REF_W);

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } sync_state_e;

  typedef struct packed {
    logic [SEL_W-1:0] len_m1;
    logic [SEL_W-1:0] tap_m1;
    logic             repeat_mode;
    logic             qrss;
  } pat_cfg_t;
endpackage

// File: rtl/bert_ref_gen.sv
module bert_ref_gen
  import bert_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pat_cfg_t cfg,
  input  logic     adv,
  input  logic     load_mode,
  input  logic     load_bit,
  output logic     pred_bit
);
  localparam int QRSS_TAP_A = 16;
  localparam int QRSS_TAP_B = 19;
  localparam int QRSS_RUN   = 14;

  logic [REF_W-1:0] ref_q, ref_d;
  logic             fb_raw, fb, zero_lock;

  always_comb begin
    if (cfg.qrss)             fb_raw = ref_q[QRSS_TAP_A] ^ ref_q[QRSS_TAP_B];
    else if (cfg.repeat_mode) fb_raw = ref_q[cfg.len_m1];
    else                      fb_raw = ref_q[cfg.len_m1] ^ ref_q[cfg.tap_m1];
    zero_lock = ~|ref_q[REF_W-2:0];
    fb        = ((cfg.qrss || !cfg.repeat_mode) && zero_lock) ? 1'b1 : fb_raw;
    pred_bit  = (cfg.qrss && ~|ref_q[QRSS_RUN-1:0]) ? 1'b1 : fb;
    ref_d     = ref_q;
    if (adv) ref_d = {ref_q[REF_W-2:0], load_mode ? load_bit : fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= '0;
    else        ref_q <= ref_d;
  end

  // R3/R5: a free-running register escapes the all-zero state on the next bit
  p_zero_escape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load_mode && (cfg.qrss || !cfg.repeat_mode) && ~|ref_q[REF_W-2:0])
      |=> ref_q[0]);
endmodule

// File: rtl/bert_sync_ctrl.sv
module bert_sync_ctrl
  import bert_rx_pkg::*;
#(
  parameter int WIN    = 64,
  parameter int THRESH = 6,
  parameter int MATCH  = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic bit_in,
  input  logic pred_bit,
  output logic hunting,
  output logic err_evt
);
  localparam int MW = $clog2(MATCH);
  localparam int CW = $clog2(WIN + 1);

  sync_state_e     state_q, state_d;
  logic [MW-1:0]   match_q, match_d;
  logic [WIN-1:0]  hist_q, hist_d;
  logic [CW-1:0]   tally_q, tally_d, tally_step;
  logic            miss;

  always_comb begin
    miss       = bit_in ^ pred_bit;
    state_d    = state_q;
    match_d    = match_q;
    hist_d     = hist_q;
    tally_d    = tally_q;
    tally_step = tally_q + CW'(miss) - CW'(hist_q[WIN-1]);
    err_evt    = adv && (state_q == ST_LOCK) && miss;
    if (adv) begin
      if (state_q == ST_HUNT) begin
        if (miss) begin
          match_d = '0;
        end else if (match_q == MW'(MATCH - 1)) begin
          match_d = '0;
          state_d = ST_LOCK;
        end else begin
          match_d = match_q + 1'b1;
        end
      end else begin
        if (tally_step >= CW'(THRESH)) begin
          state_d = ST_HUNT;
          hist_d  = '0;
          tally_d = '0;
        end else begin
          hist_d  = {hist_q[WIN-2:0], miss};
          tally_d = tally_step;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      match_q <= '0;
      hist_q  <= '0;
      tally_q <= '0;
    end else begin
      state_q <= state_d;
      match_q <= match_d;
      hist_q  <= hist_d;
      tally_q <= tally_d;
    end
  end

  assign hunting = (state_q == ST_HUNT);

  p_tally_matches_history_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tally_q) == $countones(hist_q));
  p_tally_below_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tally_q) < THRESH);
  p_hunt_clears_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hunting |-> (hist_q == '0));
  p_lock_after_full_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hunting) |-> ($past(match_q) == MW'(MATCH - 1)));
  p_no_error_in_hunt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hunting |-> !err_evt);
endmodule

// File: rtl/bert_counters.sv
module bert_counters #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             err_evt,
  input  logic             snap,
  output logic [CNT_W-1:0] bit_hold,
  output logic [CNT_W-1:0] err_hold,
  output logic             err_live_nz
);
  logic [CNT_W-1:0] bit_q, bit_d, err_q, err_d;
  logic [CNT_W-1:0] bit_hold_d, err_hold_d;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  always_comb begin
    if (snap) begin
      bit_d      = CNT_W'(adv);
      err_d      = CNT_W'(err_evt);
      bit_hold_d = bit_q;
      err_hold_d = err_q;
    end else begin
      bit_d      = adv     ? sat_inc(bit_q) : bit_q;
      err_d      = err_evt ? sat_inc(err_q) : err_q;
      bit_hold_d = bit_hold;
      err_hold_d = err_hold;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q    <= '0;
      err_q    <= '0;
      bit_hold <= '0;
      err_hold <= '0;
    end else begin
      bit_q    <= bit_d;
      err_q    <= err_d;
      bit_hold <= bit_hold_d;
      err_hold <= err_hold_d;
    end
  end

  assign err_live_nz = |err_q;

  p_hold_only_on_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> ($stable(bit_hold) && $stable(err_hold)));
  p_bit_saturates_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((&bit_q) && adv && !snap) |=> (&bit_q));
  p_err_saturates_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((&err_q) && err_evt && !snap) |=> (&err_q));
  p_flag_after_error_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> err_live_nz);
endmodule

// File: rtl/bert_rx_monitor.sv
module bert_rx_monitor
  import bert_rx_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int WIN    = 64,
  parameter int THRESH = 6,
  parameter int MATCH  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       cfg_len_m1,
  input  logic [4:0]       cfg_tap_m1,
  input  logic             cfg_repeat,
  input  logic             cfg_qrss,
  input  logic             rx_valid,
  input  logic             rx_bit,
  input  logic             pm_update,
  output logic             err_present,
  output logic             out_of_sync,
  output logic [CNT_W-1:0] bit_count_hold,
  output logic [CNT_W-1:0] err_count_hold
);
  logic [1:0] rst_pipe_q;
  logic       rst_n_sync;
  pat_cfg_t   cfg;
  logic       pred_bit, hunting, err_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe_q[1];

  always_comb begin
    cfg.len_m1      = cfg_len_m1;
    cfg.tap_m1      = cfg_tap_m1;
    cfg.repeat_mode = cfg_repeat;
    cfg.qrss        = cfg_qrss;
  end

  bert_ref_gen u_ref (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .cfg       (cfg),
    .adv       (rx_valid),
    .load_mode (hunting),
    .load_bit  (rx_bit),
    .pred_bit  (pred_bit)
  );

  bert_sync_ctrl #(.WIN(WIN), .THRESH(THRESH), .MATCH(MATCH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .adv      (rx_valid),
    .bit_in   (rx_bit),
    .pred_bit (pred_bit),
    .hunting  (hunting),
    .err_evt  (err_evt)
  );

  bert_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .adv         (rx_valid),
    .err_evt     (err_evt),
    .snap        (pm_update),
    .bit_hold    (bit_count_hold),
    .err_hold    (err_count_hold),
    .err_live_nz (err_present)
  );

  assign out_of_sync = hunting;

  // R2: an idle cycle leaves the lock state alone
  p_idle_keeps_lock_r2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !rx_valid |=> $stable(out_of_sync));
endmodule

// File: tb/bert_rx_monitor_tb.sv
module bert_rx_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  cfg_len_m1, cfg_tap_m1;
  logic        cfg_repeat, cfg_qrss;
  logic        rx_valid, rx_bit, pm_update;
  logic        err_present, out_of_sync;
  logic [31:0] bit_hold, err_hold;
  logic        s_err_present, s_oos;
  logic [3:0]  s_bit_hold, s_err_hold;

  int n_chk = 0;
  int n_fail = 0;
  int exp_bits = 0;
  int exp_errs = 0;
  logic [31:0] txsr;

  always #2 clk = ~clk;

  bert_rx_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_len_m1(cfg_len_m1), .cfg_tap_m1(cfg_tap_m1),
    .cfg_repeat(cfg_repeat), .cfg_qrss(cfg_qrss), .rx_valid(rx_valid),
    .rx_bit(rx_bit), .pm_update(pm_update), .err_present(err_present),
    .out_of_sync(out_of_sync), .bit_count_hold(bit_hold), .err_count_hold(err_hold)
  );

  bert_rx_monitor #(.CNT_W(4)) u_sat (
    .clk(clk), .rst_n(rst_n), .cfg_len_m1(cfg_len_m1), .cfg_tap_m1(cfg_tap_m1),
    .cfg_repeat(cfg_repeat), .cfg_qrss(cfg_qrss), .rx_valid(rx_valid),
    .rx_bit(rx_bit), .pm_update(pm_update), .err_present(s_err_present),
    .out_of_sync(s_oos), .bit_count_hold(s_bit_hold), .err_count_hold(s_err_hold)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Transmit pattern model built from the rules in R3, R4, R5
  function automatic logic tx_next();
    logic fb, outb;
    if (cfg_qrss)        fb = txsr[16] ^ txsr[19];
    else if (cfg_repeat) fb = txsr[cfg_len_m1];
    else                 fb = txsr[cfg_len_m1] ^ txsr[cfg_tap_m1];
    if ((cfg_qrss || !cfg_repeat) && txsr[30:0] == 31'd0) fb = 1'b1;
    outb = (cfg_qrss && txsr[13:0] == 14'd0) ? 1'b1 : fb;
    txsr = {txsr[30:0], fb};
    return outb;
  endfunction

  task automatic send_bit(input logic flip, input logic counts_err);
    logic b;
    b = tx_next();
    @(negedge clk);
    rx_valid = 1'b1;
    rx_bit   = b ^ flip;
    @(posedge clk);
    #1;
    rx_valid = 1'b0;
    exp_bits++;
    if (flip && counts_err) exp_errs++;
  endtask

  task automatic send_clean(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0, 1'b0);
  endtask

  task automatic pulse_update();
    @(negedge clk);
    pm_update = 1'b1;
    @(posedge clk);
    #1;
    pm_update = 1'b0;
  endtask

  task automatic update_and_check(input string req);
    pulse_update();
    check({req, " bit count hold"}, bit_hold, exp_bits);
    check({req, " error count hold"}, err_hold, exp_errs);
    exp_bits = 0;
    exp_errs = 0;
  endtask

  task automatic do_reset(input logic [4:0] len_m1, input logic [4:0] tap_m1,
                          input logic rep, input logic qr, input logic [31:0] seed);
    rst_n = 1'b0;
    cfg_len_m1 = len_m1; cfg_tap_m1 = tap_m1; cfg_repeat = rep; cfg_qrss = qr;
    rx_valid = 1'b0; rx_bit = 1'b0; pm_update = 1'b0;
    txsr = seed;
    exp_bits = 0; exp_errs = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic t_reset_state();
    do_reset(5'd14, 5'd13, 1'b0, 1'b0, 32'h1);
    check("R1 out_of_sync", out_of_sync, 1);
    check("R1 err_present", err_present, 0);
    check("R1 bit hold", bit_hold, 0);
    check("R1 error hold", err_hold, 0);
  endtask

  task automatic t_prbs_lock();
    send_clean(31);
    check("R3 no lock before 32 matches", out_of_sync, 1);
    send_clean(16);
    check("R3 lock on PRBS stream", out_of_sync, 0);
    update_and_check("R7 R8 hunt bits counted, hunt misses not");
  endtask

  task automatic t_idle_ignored();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      rx_bit = ~rx_bit;
    end
    @(posedge clk);
    #1;
    check("R2 lock kept across idle", out_of_sync, 0);
    update_and_check("R2 idle cycles not counted");
    send_clean(50);
    update_and_check("R2 reference not moved by idle");
  endtask

  task automatic t_five_errors();
    for (int i = 0; i < 64; i++) send_bit((i % 12 == 0) && (i < 60), 1'b1);
    check("R6 five errors keep lock", out_of_sync, 0);
    check("R7 err_present with errors", err_present, 1);
    pulse_update();
    check("R8 bit hold after five", bit_hold, 64);
    check("R8 error hold after five", err_hold, 5);
    check("R9 saturated bit count", s_bit_hold, 15);
    check("R9 small error count", s_err_hold, 5);
    check("R8 err_present cleared by update", err_present, 0);
    exp_bits = 0; exp_errs = 0;
  endtask

  task automatic t_sliding();
    send_clean(64);
    for (int i = 0; i <= 80; i++)
      send_bit(i == 0 || i == 20 || i == 40 || i == 60 || i == 70 || i == 80, 1'b1);
    check("R6 old error leaves window", out_of_sync, 0);
    send_clean(64);
  endtask

  task automatic t_six_and_relock();
    for (int i = 0; i <= 40; i++) begin
      send_bit(i % 8 == 0, 1'b1);
      if (i == 39) check("R6 still locked at five", out_of_sync, 0);
    end
    check("R6 sixth error drops lock", out_of_sync, 1);
    send_clean(31);
    check("R10 hunting after 31 clean bits", out_of_sync, 1);
    send_clean(1);
    check("R10 relock on 32nd clean bit", out_of_sync, 0);
    update_and_check("R7 R8 loss interval");
  endtask

  task automatic t_repetitive();
    do_reset(5'd7, 5'd0, 1'b1, 1'b0, 32'h1);
    send_clean(40);
    check("R4 lock on repeating pattern", out_of_sync, 0);
    pulse_update();
    exp_bits = 0; exp_errs = 0;
    for (int i = 0; i < 16; i++) send_bit(i == 5, 1'b1);
    check("R4 error seen in repetitive mode", err_present, 1);
    update_and_check("R4 repetitive counts");
  endtask

  task automatic t_qrss();
    do_reset(5'd0, 5'd0, 1'b1, 1'b1, 32'h1);
    send_clean(400);
    check("R5 lock on QRSS stream", out_of_sync, 0);
    pulse_update();
    exp_bits = 0; exp_errs = 0;
    send_clean(300);
    check("R5 lock held on QRSS", out_of_sync, 0);
    update_and_check("R5 QRSS clean interval");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset_state();
    t_prbs_lock();
    t_idle_ignored();
    t_five_errors();
    t_sliding();
    t_six_and_relock();
    t_repetitive();
    t_qrss();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule